// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block walks a ring of 16-byte receive descriptors kept in host memory, one descriptor per packet. Software sets the ring base address, the number of slots and a software index, then enables the block. The hardware index starts at slot 0. A packet may use the slot at the hardware index only while the two indices differ.

For each packet the engine does four things in order. It reads the descriptor at that slot through a single memory port. It keeps the packet buffer address from the first quadword and hands it, with the packet length, to a DMA-write requester. Once the requester reports that the payload has landed, it writes the same slot back in completion form. That write carries a done flag, the VLAN tag, the hash, the packet type, the length and a checksum error bit. Software learns of progress from the done flag instead of polling a register.

A packet that arrives while the ring is full is counted and flagged as dropped, and the input is not stalled. Checksum result, length, type, tag and hash come in on sideband inputs together with each packet. Memory words are little-endian: byte k of a descriptor sits in bits [8k+7:8k], so quadword 0 occupies bits [63:0].

The control state machine has five states:
- IDLE accepts a packet. It moves to FETCH when the ring has a free slot and stays in IDLE when the packet is dropped.
- FETCH issues the descriptor read and moves to DMA_REQ on `mem_ack`.
- DMA_REQ offers the buffer address and moves to DMA_WAIT on `dma_ready`.
- DMA_WAIT moves to WRBACK on `dma_done`.
- WRBACK writes the completion and returns to IDLE on `mem_ack`, advancing the hardware index.

Top module: `rxd_wb_engine`

## Requirements
- R1: After reset, and one cycle after `cfg_en` is low, `head_idx` is 0. While `cfg_en` is low, `pkt_ready` is 0. After reset `drop_count` is 0 and neither `mem_req` nor `dma_valid` is raised.
- R2: For the slot at hardware index i, the descriptor read and the later writeback both use address `cfg_base + 16*i`.
- R3: `dma_addr` equals quadword 0 (bits [63:0]) of the descriptor that was read, and `dma_len` equals the accepted `pkt_len`. Quadword 1 of the request form (the header buffer address) has no effect on either value.
- R4: Writeback quadword 0 (bits [63:0]) holds 0 in bits [15:0], the VLAN tag in bits [31:16] and the hash in bits [63:32].
- R5: Writeback quadword 1 (bits [127:64]) holds the done flag = 1 at bit 0, the checksum error at bit 19, the packet type at bits [37:30] and the 14-bit length at bits [51:38]. All other bits are 0.
- R6: The hardware index advances by one when the writeback is acknowledged. It wraps from `cfg_len-1` to 0.
- R7: A packet accepted while `head_idx == cfg_tail` is dropped. It raises `drop_pulse` for one cycle, increments `drop_count` and starts no memory access. `pkt_ready` stays high.
- R8: `drop_count` saturates at its all-ones value.
- R9: `mem_req` holds its address and direction until `mem_ack`. `dma_valid` holds its address and length until `dma_ready`.
- R10: `pkt_ready` is high only in IDLE. A `pkt_valid` raised while the engine is busy changes neither the write in flight nor the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Reception enable; when low, the hardware index is cleared |
| cfg_base | input | 64 | Ring base byte address (16-byte aligned) |
| cfg_len | input | IDX_W | Number of slots in the ring (at least 2) |
| cfg_tail | input | IDX_W | Software index; placement is allowed while it differs from `head_idx` |
| pkt_valid | input | 1 | Packet arrival strobe |
| pkt_ready | output | 1 | Engine can take a packet this cycle |
| pkt_len | input | 14 | Packet length in bytes |
| pkt_vlan | input | 16 | Stripped VLAN tag |
| pkt_hash | input | 32 | Hash or filter identifier |
| pkt_ptype | input | 8 | Packet type code |
| pkt_csum_bad | input | 1 | Checksum failed |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Descriptor byte address |
| mem_wdata | output | 128 | Writeback descriptor |
| mem_rdata | input | 128 | Read descriptor, valid with `mem_ack` |
| mem_ack | input | 1 | Memory request completed |
| dma_valid | output | 1 | Buffer placement request |
| dma_ready | input | 1 | Requester accepts the placement |
| dma_addr | output | 64 | Packet buffer address |
| dma_len | output | 14 | Bytes to place |
| dma_done | input | 1 | Payload fully written |
| head_idx | output | IDX_W | Hardware index |
| drop_pulse | output | 1 | One-cycle pulse per dropped packet |
| drop_count | output | DROP_W | Saturating count of drops |

## Verification
Each error in the index logic shows up at the memory port within one packet. A wrong index or a missed wrap puts the next read at the wrong byte address. A wrong full test either reads a slot while `head_idx` equals `cfg_tail` or drops a packet that should have been placed, and in both cases the error is visible on `drop_pulse` in the cycle after arrival. A latch problem in the address or the sideband fields surfaces at `dma_addr`, or in the written descriptor at the WRBACK acknowledge, a few cycles after the read. A state machine that leaves IDLE wrongly shows at once as `pkt_ready` rising while `mem_req` or `dma_valid` is still high.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;

    localparam int QW_W        = 64;
    localparam int DESC_W      = 2 * QW_W;
    localparam int SLOT_SHIFT  = 4;
    localparam int LEN_W       = 14;
    localparam int VLAN_W      = 16;
    localparam int HASH_W      = 32;
    localparam int PTYPE_W     = 8;

    // completion quadword 1 field positions
    localparam int DONE_BIT    = 0;
    localparam int CSUM_BIT    = 19;
    localparam int PTYPE_LSB   = 30;
    localparam int LEN_LSB     = 38;
    // completion quadword 0 field positions
    localparam int VLAN_LSB    = 16;
    localparam int HASH_LSB    = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DMA_REQ,
        ST_DMA_WAIT,
        ST_WRBACK
    } eng_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]   len;
        logic [VLAN_W-1:0]  vlan;
        logic [HASH_W-1:0]  hash;
        logic [PTYPE_W-1:0] ptype;
        logic               csum_bad;
    } rx_meta_t;

endpackage

// File: rtl/rxd_ring_index.sv
`timescale 1ns/1ps
module rxd_ring_index
    import rxd_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             advance,
    input  logic [IDX_W-1:0] ring_len,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [QW_W-1:0]  base,
    output logic [IDX_W-1:0] hw_idx,
    output logic [QW_W-1:0]  slot_addr,
    output logic             ring_full
);

    logic             at_last;
    logic [IDX_W-1:0] idx_next;

    always_comb begin
        at_last  = (hw_idx == ring_len - IDX_W'(1));
        idx_next = at_last ? '0 : hw_idx + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_idx <= '0;
        end else if (!en) begin
            hw_idx <= '0;
        end else if (advance) begin
            hw_idx <= idx_next;
        end
    end

    assign slot_addr = base + (QW_W'(hw_idx) << SLOT_SHIFT);
    assign ring_full = (hw_idx == sw_idx);

endmodule

// File: rtl/rxd_wb_format.sv
`timescale 1ns/1ps
module rxd_wb_format
    import rxd_pkg::*;
(
    input  rx_meta_t          meta,
    output logic [DESC_W-1:0] desc
);

    logic [QW_W-1:0] qw0;
    logic [QW_W-1:0] qw1;

    always_comb begin
        qw0 = '0;
        qw0[VLAN_LSB +: VLAN_W] = meta.vlan;
        qw0[HASH_LSB +: HASH_W] = meta.hash;

        qw1 = '0;
        qw1[DONE_BIT]                = 1'b1;
        qw1[CSUM_BIT]                = meta.csum_bad;
        qw1[PTYPE_LSB +: PTYPE_W]    = meta.ptype;
        qw1[LEN_LSB +: LEN_W]        = meta.len;
    end

    // little-endian: quadword 0 occupies the low-order bytes
    assign desc = {qw1, qw0};

endmodule

// File: rtl/rxd_drop_counter.sv
`timescale 1ns/1ps
module rxd_drop_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic             pulse,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            count <= '0;
        end else begin
            pulse <= hit;
            if (hit && count != CNT_MAX) begin
                count <= count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/rxd_wb_engine.sv
`timescale 1ns/1ps
module rxd_wb_engine
    import rxd_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DROP_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic [QW_W-1:0]     cfg_base,
    input  logic [IDX_W-1:0]    cfg_len,
    input  logic [IDX_W-1:0]    cfg_tail,
    input  logic                pkt_valid,
    output logic                pkt_ready,
    input  logic [LEN_W-1:0]    pkt_len,
    input  logic [VLAN_W-1:0]   pkt_vlan,
    input  logic [HASH_W-1:0]   pkt_hash,
    input  logic [PTYPE_W-1:0]  pkt_ptype,
    input  logic                pkt_csum_bad,
    output logic                mem_req,
    output logic                mem_we,
    output logic [QW_W-1:0]     mem_addr,
    output logic [DESC_W-1:0]   mem_wdata,
    input  logic [DESC_W-1:0]   mem_rdata,
    input  logic                mem_ack,
    output logic                dma_valid,
    input  logic                dma_ready,
    output logic [QW_W-1:0]     dma_addr,
    output logic [LEN_W-1:0]    dma_len,
    input  logic                dma_done,
    output logic [IDX_W-1:0]    head_idx,
    output logic                drop_pulse,
    output logic [DROP_W-1:0]   drop_count
);

    eng_state_e      state_q;
    eng_state_e      state_d;
    rx_meta_t        meta_q;
    rx_meta_t        meta_in;
    logic [QW_W-1:0] buf_addr_q;
    logic [QW_W-1:0] slot_addr;
    logic            ring_full;
    logic            accept;
    logic            take;
    logic            drop_hit;
    logic            advance;
    logic            unused_hdr;

    // header buffer address in the request form is not used
    assign unused_hdr = ^mem_rdata[DESC_W-1:QW_W];

    assign meta_in = '{len: pkt_len, vlan: pkt_vlan, hash: pkt_hash,
                       ptype: pkt_ptype, csum_bad: pkt_csum_bad};

    assign accept   = pkt_valid && pkt_ready;
    assign take     = accept && !ring_full;
    assign drop_hit = accept && ring_full;
    assign advance  = (state_q == ST_WRBACK) && mem_ack;

    rxd_ring_index #(.IDX_W(IDX_W)) ring_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .advance   (advance),
        .ring_len  (cfg_len),
        .sw_idx    (cfg_tail),
        .base      (cfg_base),
        .hw_idx    (head_idx),
        .slot_addr (slot_addr),
        .ring_full (ring_full)
    );

    rxd_wb_format fmt_i (
        .meta (meta_q),
        .desc (mem_wdata)
    );

    rxd_drop_counter #(.CNT_W(DROP_W)) drop_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (drop_hit),
        .pulse (drop_pulse),
        .count (drop_count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (take)      state_d = ST_FETCH;
            ST_FETCH:    if (mem_ack)   state_d = ST_DMA_REQ;
            ST_DMA_REQ:  if (dma_ready) state_d = ST_DMA_WAIT;
            ST_DMA_WAIT: if (dma_done)  state_d = ST_WRBACK;
            ST_WRBACK:   if (mem_ack)   state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        pkt_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        dma_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:     pkt_ready = cfg_en;
            ST_FETCH:    mem_req   = 1'b1;
            ST_DMA_REQ:  dma_valid = 1'b1;
            ST_DMA_WAIT: ;
            ST_WRBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // packet sideband and buffer address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q     <= '0;
            buf_addr_q <= '0;
        end else begin
            if (take) begin
                meta_q <= meta_in;
            end
            if (state_q == ST_FETCH && mem_ack) begin
                buf_addr_q <= mem_rdata[QW_W-1:0];
            end
        end
    end

    assign mem_addr = slot_addr;
    assign dma_addr = buf_addr_q;
    assign dma_len  = meta_q.len;

endmodule

// File: rtl/rxd_wb_engine_chk.sv
`timescale 1ns/1ps
module rxd_wb_engine_chk
    import rxd_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DROP_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_en,
    input logic [IDX_W-1:0]   cfg_len,
    input logic               pkt_valid,
    input logic               pkt_ready,
    input logic               mem_req,
    input logic               mem_we,
    input logic [QW_W-1:0]    mem_addr,
    input logic [DESC_W-1:0]  mem_wdata,
    input logic               mem_ack,
    input logic               dma_valid,
    input logic               dma_ready,
    input logic [QW_W-1:0]    dma_addr,
    input logic [LEN_W-1:0]   dma_len,
    input logic [IDX_W-1:0]   head_idx,
    input logic               drop_pulse,
    input logic [DROP_W-1:0]  drop_count
);

    logic [QW_W-1:0]  rd_slot_q;
    logic [IDX_W-1:0] exp_next;
    logic             unused_cnt;

    assign unused_cnt = ^drop_count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot_q <= '0;
        end else if (mem_req && !mem_we && mem_ack) begin
            rd_slot_q <= mem_addr;
        end
    end

    always_comb begin
        exp_next = (head_idx == cfg_len - IDX_W'(1)) ? '0 : head_idx + IDX_W'(1);
    end

    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !pkt_ready);

    a_r1_head_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> head_idx == '0);

    a_r2_same_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_addr == rd_slot_q);

    a_r5_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[QW_W + DONE_BIT]);

    a_r6_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && mem_req && mem_we && mem_ack) |=> head_idx == $past(exp_next));

    a_r7_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> ($past(pkt_valid) && !mem_req && !dma_valid));

    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r9_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_addr) && $stable(dma_len)));

    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (!mem_req && !dma_valid));

endmodule

bind rxd_wb_engine rxd_wb_engine_chk #(.IDX_W(IDX_W), .DROP_W(DROP_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_len    (cfg_len),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .dma_valid  (dma_valid),
    .dma_ready  (dma_ready),
    .dma_addr   (dma_addr),
    .dma_len    (dma_len),
    .head_idx   (head_idx),
    .drop_pulse (drop_pulse),
    .drop_count (drop_count)
);

// File: tb/rxd_wb_engine_tb_top.sv
`timescale 1ns/1ps
module rxd_wb_engine_tb_top;
    import rxd_pkg::*;

    localparam int IDX_W  = 6;
    localparam int DROP_W = 3;
    localparam logic [63:0] BASE = 64'h0000_1234_5670_0000;

    typedef struct packed {
        logic [13:0] len;
        logic [15:0] vlan;
        logic [31:0] hash;
        logic [7:0]  ptype;
        logic        csum;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{14'd64,    16'h0001, 32'hDEAD_BEEF, 8'h11, 1'b0},
        '{14'd1514,  16'h0FFF, 32'h0123_4567, 8'h2A, 1'b1},
        '{14'h3FFF,  16'hA5A5, 32'hFFFF_FFFF, 8'hFF, 1'b0},
        '{14'd1,     16'h0000, 32'h0000_0000, 8'h00, 1'b1},
        '{14'd9000,  16'h8100, 32'h8000_0001, 8'h5C, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic [63:0] cfg_base = BASE;
    logic [IDX_W-1:0] cfg_len = IDX_W'(4);
    logic [IDX_W-1:0] cfg_tail = '0;
    logic pkt_valid = 1'b0;
    logic pkt_ready;
    logic [13:0] pkt_len = '0;
    logic [15:0] pkt_vlan = '0;
    logic [31:0] pkt_hash = '0;
    logic [7:0] pkt_ptype = '0;
    logic pkt_csum_bad = 1'b0;
    logic mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic dma_valid;
    logic dma_ready = 1'b0;
    logic [63:0] dma_addr;
    logic [13:0] dma_len;
    logic dma_done = 1'b0;
    logic [IDX_W-1:0] head_idx;
    logic drop_pulse;
    logic [DROP_W-1:0] drop_count;

    logic dma_hold = 1'b0;
    int checks = 0;
    int errors = 0;
    int wb_cnt = 0, rd_cnt = 0, dma_cnt = 0;
    logic [63:0] rd_addr_cap, wb_addr_cap, dma_addr_cap;
    logic [13:0] dma_len_cap;
    logic [127:0] wb_data_cap;
    logic [63:0] mem_off;

    always #5 clk = ~clk;

    rxd_wb_engine #(.IDX_W(IDX_W), .DROP_W(DROP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_tail(cfg_tail), .pkt_valid(pkt_valid),
        .pkt_ready(pkt_ready), .pkt_len(pkt_len), .pkt_vlan(pkt_vlan),
        .pkt_hash(pkt_hash), .pkt_ptype(pkt_ptype), .pkt_csum_bad(pkt_csum_bad),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
        .dma_len(dma_len), .dma_done(dma_done), .head_idx(head_idx),
        .drop_pulse(drop_pulse), .drop_count(drop_count)
    );

    function automatic logic [63:0] buf_of(int i);
        return 64'h0000_7F00_0000_0040 + 64'(i) * 64'h1000;
    endfunction

    function automatic logic [63:0] exp_q0(vec_t v);
        return {v.hash, v.vlan, 16'h0000};
    endfunction

    function automatic logic [63:0] exp_q1(vec_t v);
        return {12'h000, v.len, v.ptype, 10'h000, v.csum, 18'h00000, 1'b1};
    endfunction

    assign mem_off = mem_addr - BASE;

    // descriptor memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack && !mem_we) begin
                mem_rdata <= {~buf_of(int'(mem_off[IDX_W+3:4])), buf_of(int'(mem_off[IDX_W+3:4]))};
            end
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    wb_addr_cap <= mem_addr;
                    wb_data_cap <= mem_wdata;
                    wb_cnt <= wb_cnt + 1;
                end else begin
                    rd_addr_cap <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    // DMA requester model
    always @(posedge clk) begin
        if (!rst_n) begin
            dma_ready <= 1'b0;
            dma_done  <= 1'b0;
        end else begin
            dma_ready <= dma_valid && !dma_ready && !dma_hold;
            dma_done  <= dma_valid && dma_ready;
            if (dma_valid && dma_ready) begin
                dma_addr_cap <= dma_addr;
                dma_len_cap  <= dma_len;
                dma_cnt <= dma_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input vec_t v);
        @(negedge clk);
        pkt_len = v.len; pkt_vlan = v.vlan; pkt_hash = v.hash;
        pkt_ptype = v.ptype; pkt_csum_bad = v.csum;
        pkt_valid = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic wait_wb(input int prev);
        for (int k = 0; k < 100 && wb_cnt == prev; k++) @(negedge clk);
    endtask

    task automatic run_pkt(input vec_t v, input int idx, input int nxt);
        int w;
        w = wb_cnt;
        send(v);
        wait_wb(w);
        @(negedge clk);
        check("R2 read address", 128'(rd_addr_cap), 128'(BASE + 64'(idx) * 16));
        check("R2 write address", 128'(wb_addr_cap), 128'(BASE + 64'(idx) * 16));
        check("R3 dma address", 128'(dma_addr_cap), 128'(buf_of(idx)));
        check("R3 dma length", 128'(dma_len_cap), 128'(v.len));
        check("R4 writeback qword0", 128'(wb_data_cap[63:0]), 128'(exp_q0(v)));
        check("R5 writeback qword1", 128'(wb_data_cap[127:64]), 128'(exp_q1(v)));
        check("R6 head advance", 128'(head_idx), 128'(nxt));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rc, w, dc;
        logic [63:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 head in reset", 128'(head_idx), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 drop count", 128'(drop_count), 128'(0));
        check("R1 no request", 128'({mem_req, dma_valid}), 128'(0));
        check("R1 ready while disabled", 128'(pkt_ready), 128'(0));

        cfg_tail = IDX_W'(3);
        cfg_en = 1'b1;
        @(negedge clk);

        // vector table walk: slots 0..2
        for (int i = 0; i < 3; i++) begin
            run_pkt(VEC[i], i, i + 1);
        end

        // R7: ring full, head 3 == tail 3
        rc = rd_cnt;
        send(VEC[0]);
        check("R7 drop pulse", 128'(drop_pulse), 128'(1));
        check("R7 drop count", 128'(drop_count), 128'(1));
        check("R7 ready kept", 128'(pkt_ready), 128'(1));
        @(negedge clk);
        check("R7 pulse width", 128'(drop_pulse), 128'(0));
        repeat (5) @(negedge clk);
        check("R7 no memory access", 128'(rd_cnt), 128'(rc));
        check("R7 head unchanged", 128'(head_idx), 128'(3));

        // R6: wrap from slot 3 to slot 0
        cfg_tail = IDX_W'(1);
        run_pkt(VEC[3], 3, 0);
        run_pkt(VEC[4], 0, 1);

        // R8: saturation, head 1 == tail 1
        rc = rd_cnt;
        @(negedge clk);
        pkt_valid = 1'b1;
        repeat (8) @(negedge clk);
        check("R7 ready during drops", 128'(pkt_ready), 128'(1));
        pkt_valid = 1'b0;
        check("R8 saturated count", 128'(drop_count), 128'(7));
        repeat (3) @(negedge clk);
        check("R8 no memory access", 128'(rd_cnt), 128'(rc));

        // R9 / R10: stalled requester, busy arrival ignored
        cfg_tail = IDX_W'(3);
        dma_hold = 1'b1;
        w = wb_cnt;
        dc = dma_cnt;
        send(VEC[1]);
        for (int k = 0; k < 50 && !dma_valid; k++) @(negedge clk);
        held = dma_addr;
        repeat (3) @(negedge clk);
        check("R9 valid held", 128'(dma_valid), 128'(1));
        check("R9 address held", 128'(dma_addr), 128'(held));
        check("R9 address value", 128'(dma_addr), 128'(buf_of(1)));
        check("R10 not ready when busy", 128'(pkt_ready), 128'(0));
        pkt_len = VEC[2].len; pkt_vlan = VEC[2].vlan; pkt_hash = VEC[2].hash;
        pkt_ptype = VEC[2].ptype; pkt_csum_bad = VEC[2].csum;
        pkt_valid = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
        dma_hold = 1'b0;
        wait_wb(w);
        repeat (10) @(negedge clk);
        check("R10 single writeback", 128'(wb_cnt), 128'(w + 1));
        check("R10 single placement", 128'(dma_cnt), 128'(dc + 1));
        check("R10 head once", 128'(head_idx), 128'(2));
        check("R10 fields kept", 128'(wb_data_cap[63:0]), 128'(exp_q0(VEC[1])));

        // R1: disable clears the index
        cfg_en = 1'b0;
        @(negedge clk);
        check("R1 head cleared", 128'(head_idx), 128'(0));
        check("R1 not ready", 128'(pkt_ready), 128'(0));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule